// File: doc/BRIEF.md
# Receive Queue with Trigger Level and Character Timeout

This block is the receive side store of a serial port controller. It takes each byte finished by the deserializer together with three per-byte error flags (parity, framing, break), keeps the bytes in arrival order, and presents the oldest byte on the read-data output. A read strobe on the receive buffer removes the oldest byte.

Two capacities are available when queuing is enabled: a shallow mode of 16 entries and a deep mode of 64 entries. A two-bit trigger select picks one of four fill thresholds for the current mode, and the block raises an at-trigger flag once the occupancy reaches that threshold. A character timeout flag is raised when bytes sit in the queue with no traffic for a set number of character times. This lets a driver collect short bursts that never reach the threshold.

With queuing disabled the block acts as a single holding register. A byte that arrives while one is still held overwrites the held byte and flags an overrun. A summary flag reports whether any stored byte carries an error.

Top module: `rx_fifo_ctl`

## Requirements
- R1: After reset, data_ready, at_trigger, rx_timeout, overrun and err_any are all 0.
- R2: Bytes are presented on rbr_data in arrival order. Each rbr_rd pulse while data_ready is 1 removes one byte. data_ready remains 1 until the last stored byte has been removed.
- R3: With fifo_en=1, at_trigger is 1 exactly when the occupancy is at least the selected level. For trig_sel 00, 01, 10 and 11 the levels are 1, 4, 8 and 14 when deep_mode=0, and 1, 16, 32 and 56 when deep_mode=1. With fifo_en=0, at_trigger is 0.
- R4: With fifo_en=1 and at least one byte stored, rx_timeout rises after 4 char_tick pulses with no write and no read in between. This happens whatever the occupancy is relative to the trigger level. The pulse count only advances while the queue is non-empty.
- R5: Any accepted write or any read of a byte clears rx_timeout on the next cycle and restarts the pulse count from zero.
- R6: With fifo_en=0, one byte is held. A byte arriving while data_ready is 1, without a read in the same cycle, replaces the held byte and sets overrun.
- R7: With fifo_en=1 and the queue full (16 or 64 entries, depending on the mode), an incoming byte without a read in the same cycle is discarded, the stored contents are unchanged, and overrun is set.
- R8: overrun stays set until an lsr_rd pulse. If a new overrun occurs in the same cycle as lsr_rd, overrun stays 1.
- R9: err_any is 1 while at least one stored byte carries a parity, framing or break flag. It returns to 0 once every such byte has been read or cleared.
- R10: An rx_clr pulse empties the queue, drops a byte arriving in the same cycle, and restarts the timeout count. A change of fifo_en or deep_mode empties the queue in the same way. overrun is not affected by any of these.
- R11: An rbr_rd pulse while the queue is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | A received byte is offered this cycle |
| rx_data | input | 8 | Received byte |
| rx_perr | input | 1 | Parity error on the offered byte |
| rx_ferr | input | 1 | Framing error on the offered byte |
| rx_brk | input | 1 | Break condition on the offered byte |
| rbr_rd | input | 1 | Receive buffer read strobe; removes the oldest byte |
| lsr_rd | input | 1 | Line status read strobe; clears overrun |
| fifo_en | input | 1 | 1 enables queuing, 0 selects the single holding register |
| rx_clr | input | 1 | Empty the receive queue |
| trig_sel | input | 2 | Trigger level select |
| deep_mode | input | 1 | 1 selects 64 entries, 0 selects 16 |
| char_tick | input | 1 | One pulse per character time |
| rbr_data | output | 8 | Oldest stored byte |
| data_ready | output | 1 | At least one byte is stored |
| at_trigger | output | 1 | Occupancy has reached the selected level |
| rx_timeout | output | 1 | Character timeout pending |
| overrun | output | 1 | A byte was lost or overwritten |
| err_any | output | 1 | Some stored byte carries an error flag |

## Verification
The bench targets the exact boundary of each threshold, in both modes. An off-by-one comparison would raise at_trigger one byte early or late. It fills both capacities and then offers one byte more. A block that let the extra byte through would corrupt the order of the remaining bytes, and one that dropped it silently would leave overrun clear. Two timeout edges are covered: the third versus the fourth tick, and a write or read just before expiry. A counter that is not restarted would fire early. The single-register overwrite and an overrun that coincides with a status read are both exercised, and so is the error-summary count when errored bytes are replaced or read out. A wrong count leaves err_any stuck or clears it too soon.

// File: rtl/rxq_pkg.sv
// Shared types and helpers for the receive queue.
// Assumes 8-bit characters with three error flags stored alongside.
package rxq_pkg;
    localparam int RXQ_DATA_W = 8;

    typedef struct packed {
        logic                  brk;
        logic                  ferr;
        logic                  perr;
        logic [RXQ_DATA_W-1:0] data;
    } rxq_entry_t;

    // True when the entry carries any error flag.
    function automatic logic entry_has_err(rxq_entry_t e);
        return e.brk | e.ferr | e.perr;
    endfunction

    // Threshold for select index idx in a queue of the given depth.
    function automatic int trig_level(int depth, int idx);
        case (idx)
            0:       return 1;
            1:       return depth / 4;
            2:       return depth / 2;
            default: return depth - depth / 8;
        endcase
    endfunction
endpackage

// File: rtl/rxq_store.sv
// Circular byte store with an occupancy count and an errored-entry count.
// Assumes the caller never pushes when full, never pops when empty and
// never asserts push and replace together. Replace overwrites the head.
module rxq_store
    import rxq_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          push,
    input  logic          pop,
    input  logic          replace,
    input  rxq_entry_t    din,
    output rxq_entry_t    head,
    output logic [CW-1:0] count,
    output logic          err_any
);
    rxq_entry_t    mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] err_cnt;
    logic          err_inc, err_dec;

    // Advance a pointer with wrap at the store depth.
    function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign head    = mem[rd_ptr];
    assign err_inc = (push | replace) & entry_has_err(din);
    assign err_dec = (pop | replace) & entry_has_err(head);
    assign err_any = (err_cnt != '0);

    // Storage write: push appends at the tail, replace overwrites the head.
    always_ff @(posedge clk) begin
        if (push)
            mem[wr_ptr] <= din;
        else if (replace)
            mem[rd_ptr] <= din;
    end

    // Pointer, occupancy and error-count bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count   <= '0;
            err_cnt <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            count   <= count + CW'(push) - CW'(pop);
            err_cnt <= err_cnt + CW'(err_inc) - CW'(err_dec);
        end
    end

    p_clear_empties_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (count == '0) && !err_any);
    p_count_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    p_replace_keeps_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (replace && !pop && !clear) |=> $stable(count));
    p_errors_within_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err_cnt <= count);
endmodule

// File: rtl/rxq_level.sv
// Trigger threshold decode for shallow and deep modes.
// Assumes the occupancy count is already bounded by the active depth.
module rxq_level
    import rxq_pkg::*;
#(
    parameter int SHALLOW_DEPTH = 16,
    parameter int DEEP_DEPTH    = 64,
    localparam int CW = $clog2(DEEP_DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fifo_en,
    input  logic          deep_mode,
    input  logic [1:0]    trig_sel,
    input  logic [CW-1:0] count,
    output logic          at_trigger
);
    logic [CW-1:0] thr_shallow [4];
    logic [CW-1:0] thr_deep    [4];
    logic [CW-1:0] thr;

    // Build the two threshold tables from the depths.
    for (genvar i = 0; i < 4; i++) begin : g_thr
        localparam int LS = trig_level(SHALLOW_DEPTH, i);
        localparam int LD = trig_level(DEEP_DEPTH, i);
        assign thr_shallow[i] = CW'(LS);
        assign thr_deep[i]    = CW'(LD);
    end

    // Pick the active threshold and compare against occupancy.
    always_comb begin
        thr        = deep_mode ? thr_deep[trig_sel] : thr_shallow[trig_sel];
        at_trigger = fifo_en && (count >= thr);
    end

    p_level_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en && trig_sel == 2'b00 && count != '0) |-> at_trigger);
    p_disabled_no_trig_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_en |-> !at_trigger);
endmodule

// File: rtl/rxq_timer.sv
// Character-time counter for the receive timeout.
// Assumes one tick per character time; counts only while run is high.
module rxq_timer #(
    parameter int TIMEOUT_CHARS = 4,
    localparam int TW = $clog2(TIMEOUT_CHARS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    input  logic tick,
    output logic expired
);
    logic [TW-1:0] cnt;

    assign expired = (cnt == TW'(TIMEOUT_CHARS));

    // Count ticks up to the limit; restart or idle returns to zero.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !run)
            cnt <= '0;
        else if (tick && !expired)
            cnt <= cnt + 1'b1;
    end

    p_restart_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !expired);
    p_expiry_needs_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(expired) |-> $past(tick) && $past(run));
endmodule

// File: rtl/rx_fifo_ctl.sv
// Receive queue control: accepts bytes, decides push, overwrite or drop,
// tracks overrun, trigger level and character timeout.
// Assumes rx_valid is a single-cycle pulse per received byte.
module rx_fifo_ctl
    import rxq_pkg::*;
#(
    parameter int SHALLOW_DEPTH = 16,
    parameter int DEEP_DEPTH    = 64,
    parameter int TIMEOUT_CHARS = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rx_valid,
    input  logic [RXQ_DATA_W-1:0] rx_data,
    input  logic                  rx_perr,
    input  logic                  rx_ferr,
    input  logic                  rx_brk,
    input  logic                  rbr_rd,
    input  logic                  lsr_rd,
    input  logic                  fifo_en,
    input  logic                  rx_clr,
    input  logic [1:0]            trig_sel,
    input  logic                  deep_mode,
    input  logic                  char_tick,
    output logic [RXQ_DATA_W-1:0] rbr_data,
    output logic                  data_ready,
    output logic                  at_trigger,
    output logic                  rx_timeout,
    output logic                  overrun,
    output logic                  err_any
);
    localparam int CW = $clog2(DEEP_DEPTH + 1);

    logic          en_q, deep_q;
    logic          clear, room, push, pop, replace, drop;
    logic [CW-1:0] count, cap;
    logic          expired;
    rxq_entry_t    din, head;

    assign din = '{brk: rx_brk, ferr: rx_ferr, perr: rx_perr, data: rx_data};

    // Remember the mode so that a change can empty the queue.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            deep_q <= 1'b0;
        end else begin
            en_q   <= fifo_en;
            deep_q <= deep_mode;
        end
    end

    // Decide what happens to the offered byte and the read strobe.
    always_comb begin
        clear   = rx_clr || (fifo_en != en_q) || (deep_mode != deep_q);
        cap     = !fifo_en ? CW'(1) : (deep_mode ? CW'(DEEP_DEPTH) : CW'(SHALLOW_DEPTH));
        pop     = rbr_rd && (count != '0) && !clear;
        room    = (count - CW'(pop)) < cap;
        push    = rx_valid && !clear && room;
        replace = rx_valid && !clear && !room && !fifo_en;
        drop    = rx_valid && !clear && !room && fifo_en;
    end

    // Sticky overrun; a new loss wins over the clearing status read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            overrun <= 1'b0;
        else if (replace || drop)
            overrun <= 1'b1;
        else if (lsr_rd)
            overrun <= 1'b0;
    end

    rxq_store #(.DEPTH(DEEP_DEPTH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (clear),
        .push    (push),
        .pop     (pop),
        .replace (replace),
        .din     (din),
        .head    (head),
        .count   (count),
        .err_any (err_any)
    );

    rxq_level #(.SHALLOW_DEPTH(SHALLOW_DEPTH), .DEEP_DEPTH(DEEP_DEPTH)) u_level (
        .clk        (clk),
        .rst_n      (rst_n),
        .fifo_en    (fifo_en),
        .deep_mode  (deep_mode),
        .trig_sel   (trig_sel),
        .count      (count),
        .at_trigger (at_trigger)
    );

    rxq_timer #(.TIMEOUT_CHARS(TIMEOUT_CHARS)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (fifo_en && (count != '0)),
        .restart (clear || push || pop || replace),
        .tick    (char_tick),
        .expired (expired)
    );

    assign rbr_data   = head.data;
    assign data_ready = (count != '0);
    assign rx_timeout = expired && data_ready;

    p_ovr_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !lsr_rd) |=> overrun);
    p_full_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en && rx_valid && !rbr_rd && !clear && count == cap) |=> $stable(count) && overrun);
    p_write_makes_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !clear) |=> data_ready);
    p_empty_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!data_ready && !rx_valid) |=> !data_ready);
endmodule

// File: tb/sim_rx_fifo_ctl.sv
module sim_rx_fifo_ctl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_valid = 0, rx_perr = 0, rx_ferr = 0, rx_brk = 0;
    logic [7:0] rx_data = 0;
    logic       rbr_rd = 0, lsr_rd = 0, fifo_en = 0, rx_clr = 0;
    logic [1:0] trig_sel = 0;
    logic       deep_mode = 0, char_tick = 0;
    logic [7:0] rbr_data;
    logic       data_ready, at_trigger, rx_timeout, overrun, err_any;

    int    n_checks = 0;
    int    n_fail   = 0;
    string tag      = "R1";

    // Reference state
    logic [10:0] q[$];
    bit          m_ovr;
    int          m_cnt;
    bit          p_en, p_deep;

    always #10 clk = ~clk;

    rx_fifo_ctl u0 (.*);

    function automatic int lvl(bit deep, logic [1:0] s);
        int d = deep ? 64 : 16;
        case (s)
            2'd0:    return 1;
            2'd1:    return d / 4;
            2'd2:    return d / 2;
            default: return d - d / 8;
        endcase
    endfunction

    // Reference update at every edge
    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete(); m_ovr = 0; m_cnt = 0; p_en = 0; p_deep = 0;
        end else begin
            bit clr, pop, room, push, rep, drop;
            int cap, sz;
            logic [10:0] ent;
            ent  = {rx_brk, rx_ferr, rx_perr, rx_data};
            clr  = rx_clr || (fifo_en != p_en) || (deep_mode != p_deep);
            cap  = !fifo_en ? 1 : (deep_mode ? 64 : 16);
            sz   = q.size();
            pop  = rbr_rd && sz != 0 && !clr;
            room = (sz - int'(pop)) < cap;
            push = rx_valid && !clr && room;
            rep  = rx_valid && !clr && !room && !fifo_en;
            drop = rx_valid && !clr && !room && fifo_en;
            if (clr || push || pop || rep || !fifo_en || sz == 0) m_cnt = 0;
            else if (char_tick && m_cnt < 4) m_cnt++;
            if (clr) q.delete();
            else begin
                if (pop) void'(q.pop_front());
                if (push) q.push_back(ent);
                if (rep) q[0] = ent;
            end
            if (rep || drop) m_ovr = 1;
            else if (lsr_rd) m_ovr = 0;
            p_en = fifo_en; p_deep = deep_mode;
        end
    end

    task automatic chk(string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic compare();
        bit e_any = 0;
        foreach (q[i]) if (|q[i][10:8]) e_any = 1;
        chk("data_ready R2", data_ready, q.size() != 0);
        chk("at_trigger R3", at_trigger, fifo_en && q.size() >= lvl(deep_mode, trig_sel));
        chk("rx_timeout R4", rx_timeout, (m_cnt == 4) && q.size() != 0);
        chk("overrun R8", overrun, m_ovr);
        chk("err_any R9", err_any, e_any);
        if (q.size() != 0) chk("rbr_data R2", rbr_data, q[0][7:0]);
    endtask

    // One cycle: wait for the edge, check away from it, drop pulses.
    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
        compare();
        rx_valid = 0; rbr_rd = 0; lsr_rd = 0; rx_clr = 0; char_tick = 0;
        rx_perr = 0; rx_ferr = 0; rx_brk = 0;
    endtask

    task automatic wr(logic [7:0] d, logic [2:0] e = 3'b000);
        rx_valid = 1; rx_data = d; {rx_brk, rx_ferr, rx_perr} = e;
        cyc();
    endtask
    task automatic rd();       rbr_rd = 1;    cyc(); endtask
    task automatic tk();       char_tick = 1; cyc(); endtask
    task automatic idle(int n); for (int i = 0; i < n; i++) cyc(); endtask

    initial begin
        #(200000 * 20);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        @(negedge clk); @(negedge clk);
        rst_n = 1;
        // R1 reset state
        tag = "R1";
        chk("data_ready R1", data_ready, 0);
        chk("overrun R1", overrun, 0);
        chk("rx_timeout R1", rx_timeout, 0);
        chk("at_trigger R1", at_trigger, 0);
        chk("err_any R1", err_any, 0);
        idle(2);

        // R6 single holding register overwrite
        tag = "R6";
        wr(8'h11); wr(8'h22);
        chk("held byte R6", rbr_data, 8'h22);
        chk("overrun set R6", overrun, 1);
        rd();
        tag = "R8"; lsr_rd = 1; cyc();
        chk("overrun cleared R8", overrun, 0);

        // R11 empty reads
        tag = "R11"; rd(); rd();
        chk("still empty R11", data_ready, 0);

        // R3/R7/R2 shallow mode
        tag = "R3"; fifo_en = 1; trig_sel = 2'd3; cyc();
        for (int i = 0; i < 16; i++) wr(8'(i + 8'h40));
        tag = "R7"; wr(8'hEE); wr(8'hEF);
        chk("drop keeps head R7", rbr_data, 8'h40);
        tag = "R2";
        for (int i = 0; i < 16; i++) begin trig_sel = 2'(i); rd(); end
        chk("drained R2", data_ready, 0);

        // R3/R7 deep mode
        tag = "R3"; deep_mode = 1; lsr_rd = 1; cyc();
        for (int i = 0; i < 64; i++) begin trig_sel = 2'(i / 16); wr(8'(i)); end
        tag = "R7"; wr(8'hAA);
        tag = "R8"; lsr_rd = 1; wr(8'hAB);
        chk("set wins R8", overrun, 1);
        tag = "R2"; for (int i = 0; i < 64; i++) begin trig_sel = 2'(i); rd(); end

        // R4/R5 timeout
        tag = "R4"; deep_mode = 0; trig_sel = 2'd3; cyc();
        wr(8'h01); wr(8'h02);
        tk(); tk(); tk();
        chk("no timeout at 3 R4", rx_timeout, 0);
        tk();
        chk("timeout at 4 R4", rx_timeout, 1);
        tag = "R5"; rd();
        chk("read clears R5", rx_timeout, 0);
        tk(); tk(); tk(); wr(8'h03); tk(); tk(); tk();
        chk("write restarts R5", rx_timeout, 0);
        tk(); rd(); rd();

        // R9 error summary
        tag = "R9"; wr(8'h10); wr(8'h20, 3'b010); wr(8'h30);
        chk("err set R9", err_any, 1);
        rd(); rd();
        chk("err cleared R9", err_any, 0);
        rd();

        // R10 clear and mode change
        tag = "R10"; wr(8'h5A, 3'b100); wr(8'h5B);
        rx_clr = 1; rx_valid = 1; rx_data = 8'h77; cyc();
        chk("cleared R10", data_ready, 0);
        wr(8'h61); wr(8'h62); deep_mode = 1; cyc();
        chk("mode change clears R10", data_ready, 0);

        // Random traffic
        tag = "R2";
        for (int n = 0; n < 4000; n++) begin
            if (n % 500 == 0) begin
                fifo_en   = ($urandom % 4) != 0;
                deep_mode = $urandom % 2;
            end
            if ($urandom % 50 == 0) trig_sel = 2'($urandom);
            rx_valid  = ($urandom % 100) < ((n / 250) % 2 ? 70 : 35);
            rx_data   = 8'($urandom);
            rx_perr   = ($urandom % 20) == 0;
            rx_ferr   = ($urandom % 20) == 0;
            rx_brk    = ($urandom % 30) == 0;
            rbr_rd    = ($urandom % 100) < ((n / 250) % 2 ? 30 : 45);
            char_tick = ($urandom % 100) < 30;
            lsr_rd    = ($urandom % 100) < 5;
            rx_clr    = ($urandom % 400) == 0;
            cyc();
        end

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule